// File: doc/BRIEF.md
# Byte-serial SPI master with auto-read streaming

The block is a byte-wide SPI master controlled through a small 8-bit register bus. Software sets it up through seven byte registers: enable, framing control, status, transmit data, receive data, clock shape and clock divider. A write to the transmit-data register shifts one byte out on MOSI and, in the same transfer, shifts one byte in from MISO. Bit order, idle clock level and the clock edges used for driving and for sampling can each be chosen on their own. Chip select is not part of the block.

For bulk reads, an auto-read bit changes what a receive-data read does. With auto-read set, each read of the received byte also starts the next transfer, which sends all zeros. A single write to the transmit register starts the stream. After that, a DMA engine can pull bytes by answering the block's request line with reads of the receive register, without writing the transmit register again.

Top module: `spim_top`

## Requirements
- R1: Registers are selected by byte offset: 0x00 enable (bit 0), 0x04 control (bit 0 LSB-first, bits 3:2 data-in mode with only value 0 defined as full duplex, bit 5 auto-read), 0x08 status, 0x0C transmit data, 0x10 receive data, 0x14 clock shape (bit 0 idle level, bit 1 transmit phase, bit 2 receive phase) and 0x18 divider. Undefined bits read as 0, and the transmit register reads back the last value written to it.
- R2: After reset the status register reads 0x01, and SCLK, MOSI and the DMA request are all 0.
- R3: While the enable bit is 0, transfers do not start and any running transfer stops. SCLK then sits at its idle level, MOSI is 0, and status bit 0 reads 1.
- R4: A transfer is 16 half periods, each lasting divider+1 system clock cycles. SCLK rests at the idle level and toggles at the end of every half period.
- R5: With control bit 0 at 0 the byte goes out MSB first; with it at 1, LSB first. Received bits are placed in the same order.
- R6: With transmit phase 0, each bit is on MOSI from the start of its first half period. With transmit phase 1, each bit appears at its leading SCLK edge, and MOSI is 0 during the first half period.
- R7: With receive phase 0, MISO is sampled at the leading (first) SCLK edge of each bit. With receive phase 1, it is sampled at the trailing (second) edge.
- R8: Status bit 0 (transmit empty) clears when a transfer starts. One cycle after the transfer ends, bit 1 (receive full) sets and bit 0 sets again, so status reads 0x03. A read of the receive register clears bit 1.
- R9: A transmit-data write made while a transfer is in flight starts nothing and does not change the bits on MOSI.
- R10: With auto-read set, a read of the receive register while idle starts a transfer that sends zeros. With auto-read clear, such a read starts nothing.
- R11: The DMA request is high exactly while receive full and auto-read are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (has side effects on the receive register) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| dma_req | output | 1 | Request to drain the receive register |

## Verification
The hardest case to reach is a receive phase that disagrees with the way the slave changes its data. The bench slave changes MISO at the leading edge, so sampling at the trailing edge picks up the next bit. The received byte is then shifted by one place and a fixed value can be expected (0x3C turns into 0x78). The auto-read stream is the other hard case: only a read on the bus can restart the engine. The bench reaches it with a chain of receive reads, each placed after the previous transfer has ended, while the DMA line is compared against the reference model on every cycle.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [2:0] {
    SEL_ENABLE = 3'd0,
    SEL_CTRL   = 3'd1,
    SEL_STAT   = 3'd2,
    SEL_TXD    = 3'd3,
    SEL_RXD    = 3'd4,
    SEL_SHAPE  = 3'd5,
    SEL_DIV    = 3'd6,
    SEL_NONE   = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic cpol;
    logic tx_ph;
    logic rx_ph;
  } clk_shape_t;

  // Position of serial bit number idx inside a word of the given width.
  function automatic int unsigned lane_of(input logic lsb_first,
                                          input int unsigned idx,
                                          input int unsigned width);
    return lsb_first ? idx : (width - 1 - idx);
  endfunction

  // Word-aligned offset to register select.
  function automatic reg_sel_e sel_of(input logic [4:0] addr);
    if (addr[1:0] != 2'b00 || addr[4:2] == 3'd7) return SEL_NONE;
    return reg_sel_e'(addr[4:2]);
  endfunction

endpackage

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int W     = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic [W-1:0]     tx_byte,
  input  logic             lsb_first,
  input  clk_shape_t       shape,
  input  logic [DIV_W-1:0] div,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     rx_byte
);
  localparam int IW     = $clog2(W);
  localparam int HW     = IW + 1;
  localparam int HALVES = 2 * W;

  logic [HW-1:0]    half;
  logic [DIV_W-1:0] cnt;
  logic [W-1:0]     tx_q, rx_q;
  logic             busy_q, done_q;

  // Named internal events
  logic          half_end, last_half, rx_hit, tx_valid;
  logic [HW-1:0] tx_half;
  logic [IW-1:0] rx_lane, tx_lane;

  assign half_end  = busy_q && (cnt == div);
  assign last_half = (half == HW'(HALVES - 1));
  assign rx_hit    = half_end && (shape.rx_ph ? half[0] : !half[0]);
  assign rx_lane   = IW'(lane_of(lsb_first, int'(half >> 1), W));
  assign tx_half   = shape.tx_ph ? (half - 1'b1) : half;
  assign tx_valid  = !shape.tx_ph || (half != '0);
  assign tx_lane   = IW'(lane_of(lsb_first, int'(tx_half >> 1), W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      half   <= '0;
      cnt    <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (!en) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      half   <= '0;
      cnt    <= '0;
    end else begin
      done_q <= half_end && last_half;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          half   <= '0;
          cnt    <= '0;
          tx_q   <= tx_byte;
          rx_q   <= '0;
        end
      end else if (half_end) begin
        cnt <= '0;
        if (rx_hit) rx_q[rx_lane] <= miso;
        if (last_half) busy_q <= 1'b0;
        else           half   <= half + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign sclk    = shape.cpol ^ (busy_q & half[0]);
  assign mosi    = busy_q && tx_valid && tx_q[tx_lane];
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;

  // R3: a cleared enable stops the engine at the next edge
  assert_stop_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy_q);
  // R4: the completion pulse only follows the final edge
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  // R4: the half index advances only at a divider terminal count
  assert_half_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && busy_q && !half_end) |=> $stable(half));

endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int W     = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             busy,
  input  logic             done,
  input  logic [W-1:0]     rx_byte,
  output logic             en,
  output logic             lsb_first,
  output logic             auto_rd,
  output clk_shape_t       shape,
  output logic [DIV_W-1:0] div,
  output logic             start,
  output logic [W-1:0]     start_byte,
  output logic             tx_empty,
  output logic             rx_full
);
  reg_sel_e   sel;
  logic [1:0] din_mode;
  logic [W-1:0] txd_q, rxd_q;
  logic       wr_txd, rd_rxd;

  assign sel        = sel_of(bus_addr);
  assign wr_txd     = bus_wr && (sel == SEL_TXD);
  assign rd_rxd     = bus_rd && (sel == SEL_RXD);
  assign start      = en && tx_empty && (wr_txd || (rd_rxd && auto_rd));
  assign start_byte = wr_txd ? bus_wdata[W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      lsb_first <= 1'b0;
      din_mode  <= 2'b00;
      auto_rd   <= 1'b0;
      shape     <= '0;
      div       <= '0;
      txd_q     <= '0;
    end else if (bus_wr) begin
      unique case (sel)
        SEL_ENABLE: en <= bus_wdata[0];
        SEL_CTRL: begin
          lsb_first <= bus_wdata[0];
          din_mode  <= bus_wdata[3:2];
          auto_rd   <= bus_wdata[5];
        end
        SEL_TXD:   txd_q <= bus_wdata[W-1:0];
        SEL_SHAPE: shape <= '{cpol: bus_wdata[0], tx_ph: bus_wdata[1], rx_ph: bus_wdata[2]};
        SEL_DIV:   div   <= bus_wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
      rxd_q    <= '0;
    end else begin
      if (!en)        tx_empty <= 1'b1;
      else if (done)  tx_empty <= 1'b1;
      else if (start) tx_empty <= 1'b0;
      if (done) begin
        rx_full <= 1'b1;
        rxd_q   <= rx_byte;
      end else if (rd_rxd) begin
        rx_full <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_ENABLE: bus_rdata = {7'b0, en};
      SEL_CTRL:   bus_rdata = {2'b0, auto_rd, 1'b0, din_mode, 1'b0, lsb_first};
      SEL_STAT:   bus_rdata = {6'b0, rx_full, tx_empty};
      SEL_TXD:    bus_rdata = 8'(txd_q);
      SEL_RXD:    bus_rdata = 8'(rxd_q);
      SEL_SHAPE:  bus_rdata = {5'b0, shape.rx_ph, shape.tx_ph, shape.cpol};
      SEL_DIV:    bus_rdata = 8'(div);
      default:    bus_rdata = '0;
    endcase
  end

  // R8: receive-full rises only after a completion pulse
  assert_full_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(done));
  // R8: a receive read without a coincident completion empties the buffer
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && !done) |=> !rx_full);
  // R10: an auto-read receive read while idle launches a transfer
  assert_auto_launch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && auto_rd && tx_empty && rd_rxd && !bus_wr) |=> !tx_empty);
  // R9: nothing starts while the engine is busy
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso,
  output logic       dma_req
);
  localparam int W = 8;

  logic             en, lsb_first, auto_rd, start, busy, done, tx_empty, rx_full;
  clk_shape_t       shape;
  logic [DIV_W-1:0] div;
  logic [W-1:0]     start_byte, rx_byte;

  spim_regs #(.W(W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .rx_byte(rx_byte),
    .en(en), .lsb_first(lsb_first), .auto_rd(auto_rd), .shape(shape), .div(div),
    .start(start), .start_byte(start_byte),
    .tx_empty(tx_empty), .rx_full(rx_full)
  );

  spim_engine #(.W(W), .DIV_W(DIV_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .tx_byte(start_byte),
    .lsb_first(lsb_first), .shape(shape), .div(div), .miso(miso),
    .sclk(sclk), .mosi(mosi), .busy(busy), .done(done), .rx_byte(rx_byte)
  );

  assign dma_req = rx_full && auto_rd;

  // R8: a busy engine always reads as transmit-not-empty
  assert_busy_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tx_empty);
  // R11: a receive read drops the request on the next cycle
  assert_dma_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && bus_rd && bus_addr == 5'h10 && !done) |=> !dma_req);

endmodule

// File: tb/sim_spim_top.sv
module sim_spim_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [4:0] bus_addr = 5'h08;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, miso = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sclk, mosi, dma_req;

  int nchecks = 0, nerr = 0;

  spim_top u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .dma_req(dma_req));

  always #4 clk = ~clk;

  // ---------------- reference model ----------------
  logic m_en, m_lsb, m_auto, m_cpol, m_txph, m_rxph, m_te, m_rf, m_busy, m_done;
  logic [1:0] m_din;
  logic [7:0] m_div, m_td, m_rd, m_txb, m_acc, m_sl;
  int   m_t, sidx;
  logic [7:0] slave_q [16];

  function automatic logic [7:0] m_read(input logic [4:0] a);
    if (a[1:0] != 0) return 8'h00;
    case (a[4:2])
      3'd0: return {7'b0, m_en};
      3'd1: return {2'b0, m_auto, 1'b0, m_din, 1'b0, m_lsb};
      3'd2: return {6'b0, m_rf, m_te};
      3'd3: return m_td;
      3'd4: return m_rd;
      3'd5: return {5'b0, m_rxph, m_txph, m_cpol};
      3'd6: return m_div;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int m_half();
    return m_t / (int'(m_div) + 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_lsb = 0; m_auto = 0; m_cpol = 0; m_txph = 0; m_rxph = 0; m_din = 0;
      m_te = 1; m_rf = 0; m_busy = 0; m_done = 0; m_div = 0; m_td = 0; m_rd = 0;
      m_txb = 0; m_acc = 0; m_t = 0;
    end else begin
      int  h;
      logic edge_now, wr_td, rd_rx, start, ndone, old_en;
      h        = m_half();
      edge_now = m_busy && ((m_t % (int'(m_div) + 1)) == int'(m_div));
      wr_td    = bus_wr && bus_addr == 5'h0C;
      rd_rx    = bus_rd && bus_addr == 5'h10;
      start    = m_en && m_te && (wr_td || (rd_rx && m_auto));
      ndone    = m_en && edge_now && h == 15;
      old_en   = m_en;
      // receive register and flags
      if (m_done) begin m_rf = 1; m_rd = m_acc; end
      else if (rd_rx) m_rf = 0;
      if (!old_en || m_done) m_te = 1;
      else if (start) m_te = 0;
      // serial engine
      if (!old_en) begin m_busy = 0; m_t = 0; end
      else if (!m_busy) begin
        if (start) begin
          m_busy = 1; m_t = 0; m_txb = wr_td ? bus_wdata : 8'h00; m_acc = 0;
          m_sl = slave_q[sidx]; sidx++;
        end
      end else begin
        if (edge_now && (m_rxph ? (h % 2 == 1) : (h % 2 == 0)))
          m_acc[m_lsb ? h / 2 : 7 - h / 2] = miso;
        if (edge_now && h == 15) m_busy = 0;
        else m_t++;
      end
      m_done = ndone;
      // register writes
      if (bus_wr) case (bus_addr)
        5'h00: m_en = bus_wdata[0];
        5'h04: begin m_lsb = bus_wdata[0]; m_din = bus_wdata[3:2]; m_auto = bus_wdata[5]; end
        5'h0C: m_td = bus_wdata;
        5'h14: begin m_cpol = bus_wdata[0]; m_txph = bus_wdata[1]; m_rxph = bus_wdata[2]; end
        5'h18: m_div = bus_wdata;
        default: ;
      endcase
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle compare, then the slave drives MISO for the next edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic e_sclk, e_mosi;
      int h, i;
      h = m_half();
      e_sclk = m_cpol ^ (m_busy && (h % 2 == 1));
      e_mosi = 0;
      if (m_busy && (!m_txph || h != 0)) begin
        i = m_txph ? (h - 1) / 2 : h / 2;
        e_mosi = m_txb[m_lsb ? i : 7 - i];
      end
      chk("R4 sclk", {7'b0, sclk}, {7'b0, e_sclk});
      chk("R5 R6 mosi", {7'b0, mosi}, {7'b0, e_mosi});
      chk("R11 dma_req", {7'b0, dma_req}, {7'b0, m_rf && m_auto});
      chk(bus_addr == 5'h08 ? "R8 status" : (bus_addr == 5'h10 ? "R7 rxdata" : "R1 regread"),
          bus_rdata, m_read(bus_addr));
      if (m_busy) begin
        i = (h + 1) / 2;
        miso = (i > 7) ? 1'b0 : m_sl[m_lsb ? i : 7 - i];
      end else miso = 1'b0;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(posedge clk); #1 bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0; bus_addr = 5'h08;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(posedge clk); #1 bus_addr = a; bus_rd = 1;
    @(negedge clk); d = bus_rdata;
    @(posedge clk); #1 bus_rd = 0; bus_addr = 5'h08;
  endtask

  task automatic wait_xfer();
    repeat (16 * (int'(m_div) + 1) + 4) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog R4 actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    slave_q = '{8'h3C, 8'h3C, 8'hC3, 8'h96, 8'h3C, 8'h5A, 8'h00, 8'hA1,
                8'hB2, 8'hC3, 8'hD4, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    sidx = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk("R2 status", bus_rdata, 8'h01);
    chk("R2 sclk mosi dma", {5'b0, sclk, mosi, dma_req}, 8'h00);

    // R1 register map and reserved bits
    wr(5'h00, 8'h01);
    wr(5'h04, 8'hFF); rd(5'h04, v); chk("R1 control", v, 8'h2D);
    wr(5'h14, 8'hFF); rd(5'h14, v); chk("R1 shape", v, 8'h07);
    wr(5'h18, 8'h5A); rd(5'h18, v); chk("R1 divider", v, 8'h5A);
    rd(5'h00, v); chk("R1 enable", v, 8'h01);
    rd(5'h1C, v); chk("R1 unmapped", v, 8'h00);
    wr(5'h04, 8'h00); wr(5'h14, 8'h00); wr(5'h18, 8'h01);

    // R4 R5 mode 0, MSB first
    wr(5'h0C, 8'hA5);
    rd(5'h0C, v); chk("R1 txdata readback", v, 8'hA5);
    wait_xfer();
    rd(5'h08, v); chk("R8 status done", v, 8'h03);
    rd(5'h10, v); chk("R5 rx msb", v, 8'h3C);
    rd(5'h08, v); chk("R8 status after read", v, 8'h01);

    // R5 LSB first
    wr(5'h04, 8'h01); wr(5'h0C, 8'h6E); wait_xfer();
    rd(5'h10, v); chk("R5 rx lsb", v, 8'h3C);
    wr(5'h04, 8'h00);

    // R4 idle high clock, divider 0
    wr(5'h14, 8'h01); wr(5'h18, 8'h00); wr(5'h0C, 8'h81); wait_xfer();
    rd(5'h10, v); chk("R4 rx cpol1", v, 8'hC3);

    // R6 transmit phase 1, divider 2
    wr(5'h14, 8'h02); wr(5'h18, 8'h02); wr(5'h0C, 8'h4B); wait_xfer();
    rd(5'h10, v); chk("R6 rx txph1", v, 8'h96);

    // R7 receive phase 1 against a leading-edge slave
    wr(5'h14, 8'h04); wr(5'h18, 8'h01); wr(5'h0C, 8'h00); wait_xfer();
    rd(5'h10, v); chk("R7 rx rxph1", v, 8'h78);
    wr(5'h14, 8'h00);

    // R9 write during a transfer
    wr(5'h0C, 8'h11);
    repeat (5) @(posedge clk);
    wr(5'h0C, 8'hEE);
    rd(5'h08, v); chk("R9 still busy", v, 8'h00);
    wait_xfer();
    rd(5'h10, v); chk("R9 rx", v, 8'h5A);

    // R3 abort by disable, then writes while disabled
    wr(5'h0C, 8'hFF);
    repeat (6) @(posedge clk);
    wr(5'h00, 8'h00);
    rd(5'h08, v); chk("R3 abort status", v, 8'h01);
    wr(5'h0C, 8'h77);
    repeat (6) @(posedge clk); #1;
    chk("R3 idle outputs", {6'b0, sclk, mosi}, 8'h00);
    rd(5'h08, v); chk("R3 no start", v, 8'h01);
    wr(5'h00, 8'h01);

    // R10 receive read without auto-read starts nothing
    rd(5'h10, v);
    repeat (4) @(posedge clk); #1;
    chk("R10 no auto sclk", {7'b0, sclk}, 8'h00);
    rd(5'h08, v); chk("R10 no auto status", v, 8'h01);

    // R10 R11 auto-read stream
    wr(5'h04, 8'h20);
    wr(5'h0C, 8'h00); wait_xfer();
    chk("R11 request high", {7'b0, dma_req}, 8'h01);
    rd(5'h10, v); chk("R10 stream 0", v, 8'hA1);
    chk("R11 request dropped", {7'b0, dma_req}, 8'h00);
    wait_xfer();
    rd(5'h10, v); chk("R10 stream 1", v, 8'hB2);
    wait_xfer();
    rd(5'h10, v); chk("R10 stream 2", v, 8'hC3);
    wait_xfer();
    wr(5'h04, 8'h00);
    chk("R11 no request without auto", {7'b0, dma_req}, 8'h00);
    rd(5'h10, v); chk("R10 stream 3", v, 8'hD4);
    repeat (4) @(posedge clk); #1;
    rd(5'h08, v); chk("R10 stream stopped", v, 8'h01);

    repeat (4) @(posedge clk);
    summary();
    $finish;
  end
endmodule